// File: doc/BRIEF.md
# I2C ADC Channel Polling Controller

This block keeps four 12-bit parallel registers filled with the newest conversion results from a four-channel serial ADC. The ADC sits on an I2C bus. The block does not drive the bus pins itself. It commands a byte-level I2C master through an enable, a 7-bit address, a read/write select, and a busy/read-data/ack-error return path. The master runs one byte per busy pulse. It keeps chaining bytes while enable stays high, and it closes with a stop once enable has dropped.

The controller has four states:
- `ST_START` waits out a 100 ms power-up hold. The hold length is counted in system clock cycles from the `CLK_HZ` parameter.
- `ST_READ` fetches eight bytes in one read transaction. The bytes form four 16-bit words, two bytes per word, first byte most significant.
- `ST_ROUTE` decodes the 4-bit header of each word. Valid words are written into the output register selected by the header's channel ID.
- `ST_RETRY` is a one-cycle recovery after the master reports a missing acknowledge.

The transitions are:
- START→READ when the hold expires.
- READ→ROUTE when the eighth byte completes.
- READ→RETRY when a byte completes with an ack error.
- ROUTE→READ at once.
- RETRY→READ once busy is low.
- Any state→START on reset.

Top module: `adc_poll_ctrl`

## Requirements
- R1: After reset is released, `i2c_ena` stays low for at least CLK_HZ/10 clock cycles. It rises within two cycles after that count.
- R2: Whenever `i2c_ena` is high, `i2c_addr` equals `SLAVE_ADDR` (default 7'h28) and `i2c_rw` is 1, which selects a read.
- R3: Each transaction is exactly eight bytes long. `i2c_ena` stays high until the eighth byte has started, which the master shows with a rising edge on `i2c_busy`. `i2c_ena` is low by the time that byte completes.
- R4: Completed bytes are captured on each falling edge of `i2c_busy`. Word k is {byte 2k, byte 2k+1}. In each word, bits [15:14] must be 00, bits [13:12] hold the channel ID, and bits [11:0] hold the result.
- R5: A valid word writes its 12-bit result to the output register of its channel ID, whatever its slot position. When two valid words in one transaction name the same channel, the word in the higher slot wins.
- R6: A word whose bits [15:14] are not 00 is discarded. The output register of its claimed channel keeps its previous value.
- R7: After routing, the next read transaction starts without any further hold, so the outputs follow changing ADC data.
- R8: `ack_err_flag` goes high when a byte completes with `i2c_ack_err` set. That transaction is abandoned and no outputs change. The flag returns low after the next transaction that completes all eight bytes.
- R9: An asynchronous active-low reset clears all four outputs, `ack_err_flag` and `i2c_ena`, abandons any transaction, and restarts the full power-up hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i2c_ena | output | 1 | Command enable to the byte-level I2C master |
| i2c_addr | output | 7 | Slave address to the master |
| i2c_rw | output | 1 | Direction to the master, 1 = read |
| i2c_busy | input | 1 | Master busy; rising edge = byte started, falling edge = byte done |
| i2c_rdata | input | 8 | Byte read by the master, valid when busy falls |
| i2c_ack_err | input | 1 | Master's missing-acknowledge indication |
| ack_err_flag | output | 1 | High after an unacknowledged transfer until a clean one |
| ch0_data | output | 12 | Latest result for channel 0 |
| ch1_data | output | 12 | Latest result for channel 1 |
| ch2_data | output | 12 | Latest result for channel 2 |
| ch3_data | output | 12 | Latest result for channel 3 |

## Verification
The bench builds the block with CLK_HZ = 1000, which shrinks the power-up hold to 100 cycles. At that size both the first hold and a second hold after a mid-transaction reset can be measured cycle by cycle. It also leaves room for many complete read transactions.

A behavioural byte master serves word patterns generated arithmetically. The patterns sweep every rotation of channel order with varied data, and add duplicate channel IDs, each of the three bad header prefixes, and missing acknowledges injected on a chosen byte.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;
    typedef enum logic [1:0] {
        ST_START,
        ST_READ,
        ST_ROUTE,
        ST_RETRY
    } poll_state_t;

    localparam int NCH        = 4;
    localparam int DATA_W     = 12;
    localparam int WORD_W     = 16;
    localparam int ID_W       = $clog2(NCH);
    localparam int PAD_W      = WORD_W - DATA_W - ID_W;
    localparam int BYTES_PER  = WORD_W / 8;
    localparam int NBYTES     = NCH * BYTES_PER;
    localparam int BIDX_W     = $clog2(NBYTES);
    localparam int CNT_W      = $clog2(NBYTES + 1);
endpackage

// File: rtl/adc_poll_hold.sv
module adc_poll_hold #(
    parameter int HOLD_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(HOLD_CYCLES - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Once the hold has expired it stays expired until reset (R1)
    assert_hold_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/adc_poll_seq.sv
module adc_poll_seq
    import adc_poll_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h28
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hold_done,
    input  logic                         busy,
    input  logic [7:0]                   rdata,
    input  logic                         ack_err,
    output logic                         ena,
    output logic [6:0]                   addr,
    output logic                         rw,
    output logic                         err_flag,
    output logic                         route_stb,
    output logic [NCH-1:0][WORD_W-1:0]   words
);
    poll_state_t state, next;

    logic                   busy_q;
    logic                   rise, fall;
    logic [CNT_W-1:0]       rise_cnt, fall_cnt;
    logic [NBYTES-1:0][7:0] bytes_q;

    assign rise = busy & ~busy_q;
    assign fall = ~busy & busy_q;

    assign addr      = SLAVE_ADDR;
    assign rw        = 1'b1;
    assign route_stb = (state == ST_ROUTE);

    for (genvar k = 0; k < NCH; k++) begin : g_word
        assign words[k] = {bytes_q[BYTES_PER*k], bytes_q[BYTES_PER*k+1]};
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_START: if (hold_done) next = ST_READ;
            ST_READ: begin
                if (fall && ack_err)
                    next = ST_RETRY;
                else if (fall && fall_cnt == CNT_W'(NBYTES - 1))
                    next = ST_ROUTE;
            end
            ST_ROUTE: next = ST_READ;
            ST_RETRY: if (!busy) next = ST_READ;
            default:  next = ST_START;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_START;
        else        state <= next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            ena      <= 1'b0;
            err_flag <= 1'b0;
            rise_cnt <= '0;
            fall_cnt <= '0;
            bytes_q  <= '0;
        end else begin
            busy_q <= busy;
            unique case (state)
                ST_START: ena <= 1'b0;
                ST_READ: begin
                    if (rise) begin
                        rise_cnt <= rise_cnt + 1'b1;
                        if (rise_cnt == CNT_W'(NBYTES - 1)) ena <= 1'b0;
                    end
                    if (fall) begin
                        bytes_q[fall_cnt[BIDX_W-1:0]] <= rdata;
                        fall_cnt <= fall_cnt + 1'b1;
                        if (ack_err) begin
                            err_flag <= 1'b1;
                            ena      <= 1'b0;
                        end
                    end
                end
                ST_ROUTE: err_flag <= 1'b0;
                ST_RETRY: ena <= 1'b0;
                default:  ena <= 1'b0;
            endcase
            if (next == ST_READ && state != ST_READ) begin
                ena      <= 1'b1;
                rise_cnt <= '0;
                fall_cnt <= '0;
            end
        end
    end

    assert_quiet_in_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_START |-> !ena);

    assert_full_before_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ROUTE |-> (fall_cnt == CNT_W'(NBYTES) && !ena));

    assert_err_only_on_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> state == ST_RETRY);

    assert_no_route_after_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RETRY |-> !route_stb);
endmodule

// File: rtl/adc_poll_route.sv
module adc_poll_route
    import adc_poll_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        stb,
    input  logic [NCH-1:0][WORD_W-1:0]  words,
    output logic [NCH-1:0][DATA_W-1:0]  ch_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else if (stb) begin
            for (int k = 0; k < NCH; k++) begin
                if (words[k][WORD_W-1 -: PAD_W] == '0)
                    ch_q[words[k][DATA_W +: ID_W]] <= words[k][DATA_W-1:0];
            end
        end
    end

    // Outputs move only on a routing strobe (R6, R8)
    assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(ch_q));
endmodule

// File: rtl/adc_poll_ctrl.sv
module adc_poll_ctrl
    import adc_poll_pkg::*;
#(
    parameter int         CLK_HZ     = 50_000_000,
    parameter logic [6:0] SLAVE_ADDR = 7'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              i2c_ena,
    output logic [6:0]        i2c_addr,
    output logic              i2c_rw,
    input  logic              i2c_busy,
    input  logic [7:0]        i2c_rdata,
    input  logic              i2c_ack_err,
    output logic              ack_err_flag,
    output logic [DATA_W-1:0] ch0_data,
    output logic [DATA_W-1:0] ch1_data,
    output logic [DATA_W-1:0] ch2_data,
    output logic [DATA_W-1:0] ch3_data
);
    localparam int HOLD_CYCLES = CLK_HZ / 10;

    logic                       hold_done;
    logic                       route_stb;
    logic [NCH-1:0][WORD_W-1:0] words;
    logic [NCH-1:0][DATA_W-1:0] ch_q;

    adc_poll_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .done (hold_done)
    );

    adc_poll_seq #(.SLAVE_ADDR(SLAVE_ADDR)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_done(hold_done),
        .busy     (i2c_busy),
        .rdata    (i2c_rdata),
        .ack_err  (i2c_ack_err),
        .ena      (i2c_ena),
        .addr     (i2c_addr),
        .rw       (i2c_rw),
        .err_flag (ack_err_flag),
        .route_stb(route_stb),
        .words    (words)
    );

    adc_poll_route u_route (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (route_stb),
        .words(words),
        .ch_q (ch_q)
    );

    assign ch0_data = ch_q[0];
    assign ch1_data = ch_q[1];
    assign ch2_data = ch_q[2];
    assign ch3_data = ch_q[3];

    // Bus requests always read from the configured slave (R2)
    assert_read_from_slave_R2: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_ena |-> (i2c_addr == SLAVE_ADDR && i2c_rw));
endmodule

// File: tb/tb_adc_poll_ctrl.sv
module tb_adc_poll_ctrl;
    localparam int CLK_HZ = 1000;
    localparam int HOLD   = CLK_HZ / 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i2c_ena;
    logic [6:0]  i2c_addr;
    logic        i2c_rw;
    logic        i2c_busy = 1'b0;
    logic [7:0]  i2c_rdata = 8'h00;
    logic        i2c_ack_err = 1'b0;
    logic        ack_err_flag;
    logic [11:0] ch0_data, ch1_data, ch2_data, ch3_data;

    logic [15:0] pat [4];
    logic [11:0] expv [4];
    int nack_at   = -1;
    int trans_cnt = 0;
    int bus_bad   = 0;
    int last_bytes = 0;
    logic ena_at_end = 1'b0;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_poll_ctrl #(.CLK_HZ(CLK_HZ), .SLAVE_ADDR(7'h28)) dut (
        .clk(clk), .rst_n(rst_n),
        .i2c_ena(i2c_ena), .i2c_addr(i2c_addr), .i2c_rw(i2c_rw),
        .i2c_busy(i2c_busy), .i2c_rdata(i2c_rdata), .i2c_ack_err(i2c_ack_err),
        .ack_err_flag(ack_err_flag),
        .ch0_data(ch0_data), .ch1_data(ch1_data),
        .ch2_data(ch2_data), .ch3_data(ch3_data)
    );

    // Behavioural byte-level master
    initial begin : master
        logic [15:0] snap [4];
        int nb;
        forever begin
            @(negedge clk);
            if (rst_n && i2c_ena) begin
                snap = pat;
                nb = 0;
                if (i2c_addr != 7'h28 || i2c_rw != 1'b1) bus_bad++;
                for (int b = 0; b < 8; b++) begin
                    i2c_ack_err = 1'b0;
                    i2c_busy = 1'b1;
                    repeat (3) @(negedge clk);
                    if (!rst_n) begin i2c_busy = 1'b0; break; end
                    i2c_rdata = (b % 2 == 0) ? snap[b/2][15:8] : snap[b/2][7:0];
                    i2c_ack_err = (b == nack_at);
                    i2c_busy = 1'b0;
                    nb = b + 1;
                    @(negedge clk);
                    if (i2c_ack_err || !i2c_ena || !rst_n) break;
                end
                last_bytes = nb;
                ena_at_end = i2c_ena;
                if (nb == 8 && !i2c_ack_err) trans_cnt++;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [15:0] w [4]);
        for (int k = 0; k < 4; k++)
            if (w[k][15:14] == 2'b00) expv[w[k][13:12]] = w[k][11:0];
    endtask

    task automatic wait_trans(int n);
        int s = trans_cnt;
        while (trans_cnt < s + n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_outs(string req);
        chk(req, ch0_data, expv[0]);
        chk(req, ch1_data, expv[1]);
        chk(req, ch2_data, expv[2]);
        chk(req, ch3_data, expv[3]);
    endtask

    task automatic measure_hold();
        int c = 0;
        while (!i2c_ena && c < HOLD + 20) begin @(posedge clk); c++; end
        // R1: enable only after the full hold
        chk("R1", (c >= HOLD && c <= HOLD + 2), 1);
    endtask

    task automatic apply(input logic [15:0] w [4]);
        pat = w;
        model(w);
        wait_trans(2);
    endtask

    initial begin : stim
        logic [15:0] w [4];
        for (int k = 0; k < 4; k++) begin
            pat[k] = {2'b00, 2'(k), 12'(16'h100 * k + 16'h0A5)};
            expv[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", i2c_ena, 0);
        chk("R9", ack_err_flag, 0);
        check_outs("R9");

        rst_n = 1'b1;
        measure_hold();
        model(pat);
        wait_trans(1);
        chk("R2", bus_bad, 0);
        chk("R3", last_bytes, 8);
        chk("R3", ena_at_end, 0);
        check_outs("R4");

        // R5/R7: rotations of channel order with changing data
        for (int rot = 0; rot < 4; rot++) begin
            for (int sd = 0; sd < 3; sd++) begin
                for (int k = 0; k < 4; k++)
                    w[k] = {2'b00, 2'((k + rot) % 4),
                            12'((sd * 1117 + k * 331 + rot * 59 + 7) % 4096)};
                if (sd == 2) begin
                    logic [15:0] t;
                    t = w[0]; w[0] = w[3]; w[3] = t;
                end
                apply(w);
                check_outs("R5");
            end
        end

        // R5: same channel in every slot, highest slot wins
        for (int k = 0; k < 4; k++) w[k] = {4'b0010, 12'(12'h300 + k)};
        apply(w);
        check_outs("R5");
        chk("R5", ch2_data, 12'h303);

        // R6: each bad header prefix, channel keeps previous value
        for (int p = 1; p < 4; p++) begin
            for (int k = 0; k < 4; k++) w[k] = {2'b00, 2'(k), 12'(12'h800 + p * 16 + k)};
            w[1] = {2'(p), 2'b01, 12'hEEE};
            apply(w);
            check_outs("R6");
            chk("R6", ch1_data == 12'hEEE, 0);
        end

        // R8: missing acknowledge on byte 3
        nack_at = 3;
        repeat (10) @(negedge clk);
        for (int k = 0; k < 4; k++) pat[k] = {2'b00, 2'(k), 12'(12'h5A0 + k)};
        repeat (200) @(negedge clk);
        chk("R8", ack_err_flag, 1);
        check_outs("R8");
        nack_at = -1;
        model(pat);
        wait_trans(2);
        chk("R8", ack_err_flag, 0);
        check_outs("R8");

        // R9: reset in the middle of a transfer
        while (!i2c_busy) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", i2c_ena, 0);
        chk("R9", ack_err_flag, 0);
        for (int k = 0; k < 4; k++) expv[k] = '0;
        check_outs("R9");
        rst_n = 1'b1;
        measure_hold();
        model(pat);
        wait_trans(1);
        check_outs("R7");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule